// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block keeps the interrupt state of a single DMA channel. The channel datapath reports events as one-cycle strobes: descriptor completion on either side, transfer completion, pause, several bus errors and byte-count overflow. Each strobe latches a bit in a 12-bit raw status register. A 12-bit mask register selects which status bits may drive the single level-sensitive interrupt output. Software never writes the mask directly. One write-only port unmasks bits and another masks them, so that two agents can change separate bits without a read-modify-write race.

Two 8-bit counters record how many descriptors have completed on the source and destination sides since software last read them. A read returns the count and clears it. When a counter wraps past its maximum, a dedicated accounting-error status bit is set. An access to an address that the block does not decode sets an invalid-access status bit.

Top module: `dma_chan_irq_ctl`

## Requirements
- R1: After reset the status register and both counters are zero, the mask is all ones (every source masked), and `irqOut` is low.
- R2: Each event strobe sets its own status bit on the clock edge where it is sampled high. Bit 11 is pause, 10 transfer done, 9 write-data bus error, 8 read-data bus error, 7 destination descriptor read error, 6 source descriptor read error, 3 byte-count overflow, 2 destination descriptor done and 1 source descriptor done.
- R3: `irqOut` is high exactly when some status bit is 1 and its mask bit is 0. It follows the registers with no added delay.
- R4: A write to the enable address (2) clears every mask bit written as 1 and leaves all other mask bits unchanged.
- R5: A write to the disable address (3) sets every mask bit written as 1 and leaves all other mask bits unchanged.
- R6: A write to the status address (0) clears each status bit written as 1. If an event sets the same bit in the same cycle, the bit stays 1.
- R7: Each source descriptor-done strobe adds one to the source counter. Each destination descriptor-done strobe adds one to the destination counter.
- R8: When a counter at 255 is incremented it becomes 0 and sets its accounting-error status bit: bit 4 for the source counter, bit 5 for the destination counter.
- R9: A read of a counter address (4 source, 5 destination) returns the count and clears the counter. An increment in the same cycle leaves the counter at 1 and does not count as a wrap.
- R10: A read or write to any address above 5 sets status bit 0 and changes no other state. A write to the mask address (1) or to a counter address is ignored.
- R11: Read data appears on `regRdata` in the cycle after `regRd` is sampled and reflects the state before that edge. Address 0 reads the status, 1 the mask, 4 and 5 the zero-extended counters. Addresses 2, 3 and all undecoded addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtSrcDone | input | 1 | Source descriptor completed |
| evtDstDone | input | 1 | Destination descriptor completed |
| evtXferDone | input | 1 | Whole transfer completed |
| evtPause | input | 1 | Channel paused |
| evtWrDataErr | input | 1 | Bus error on data write |
| evtRdDataErr | input | 1 | Bus error on data read |
| evtDstDscrErr | input | 1 | Bus error fetching destination descriptor |
| evtSrcDscrErr | input | 1 | Bus error fetching source descriptor |
| evtByteOvfl | input | 1 | Byte counter overflowed |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | 12 | Write data |
| regRdata | output | 12 | Read data, valid the cycle after a read |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 4-bit address, which gives ten undecoded addresses above the six registers, and 8-bit counters. With 8-bit counters, a full wrap takes 256 strobes, so the bench can drive every counter value up to and past the wrap on both sides. The bench sweeps every event strobe, every undecoded address (both read and write) and every event-driven mask bit through unmask, cross-unmask and re-mask. It also drives the simultaneous cases: a status clear in the same cycle as an event, and a counter read in the same cycle as an increment.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int STAT_W = 12;

  // status bit positions
  localparam int B_BAD_ACCESS  = 0;
  localparam int B_SRC_DONE    = 1;
  localparam int B_DST_DONE    = 2;
  localparam int B_BYTE_OVFL   = 3;
  localparam int B_SRC_ACCT    = 4;
  localparam int B_DST_ACCT    = 5;
  localparam int B_SRC_DSCR    = 6;
  localparam int B_DST_DSCR    = 7;
  localparam int B_RD_DATA     = 8;
  localparam int B_WR_DATA     = 9;
  localparam int B_XFER_DONE   = 10;
  localparam int B_PAUSE       = 11;

  // register word addresses
  localparam int A_STATUS  = 0;
  localparam int A_MASK    = 1;
  localparam int A_ENABLE  = 2;
  localparam int A_DISABLE = 3;
  localparam int A_SRC_CNT = 4;
  localparam int A_DST_CNT = 5;
  localparam int NUM_REGS  = 6;

  typedef struct packed {
    logic [STAT_W-1:0] w1c;       // status bits to clear
    logic [STAT_W-1:0] maskSet;   // mask bits to set
    logic [STAT_W-1:0] maskClr;   // mask bits to clear
    logic              srcClr;    // source counter read-clear
    logic              dstClr;    // destination counter read-clear
    logic              badAccess; // undecoded address touched
  } ctlStrb_t;
endpackage

// File: rtl/irq_ctl_ctrl.sv
module irq_ctl_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [STAT_W-1:0] regWdata,
  input  logic [STAT_W-1:0] statusQ,
  input  logic [STAT_W-1:0] maskQ,
  input  logic [CNT_W-1:0]  srcCnt,
  input  logic [CNT_W-1:0]  dstCnt,
  output ctlStrb_t          strb,
  output logic [STAT_W-1:0] regRdata
);
  logic addrOk;
  logic [STAT_W-1:0] rdMux;

  assign addrOk = int'(regAddr) < NUM_REGS;

  always_comb begin
    strb = '0;
    if (regWr && addrOk) begin
      case (int'(regAddr))
        A_STATUS:  strb.w1c     = regWdata;
        A_ENABLE:  strb.maskClr = regWdata;
        A_DISABLE: strb.maskSet = regWdata;
        default:   ;
      endcase
    end
    if (regRd && addrOk) begin
      strb.srcClr = int'(regAddr) == A_SRC_CNT;
      strb.dstClr = int'(regAddr) == A_DST_CNT;
    end
    strb.badAccess = (regWr || regRd) && !addrOk;
  end

  always_comb begin
    case (int'(regAddr))
      A_STATUS:  rdMux = statusQ;
      A_MASK:    rdMux = maskQ;
      A_SRC_CNT: rdMux = STAT_W'(srcCnt);
      A_DST_CNT: rdMux = STAT_W'(dstCnt);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdata <= '0;
    else if (regRd) regRdata <= rdMux;
  end

  // R10: an undecoded access never produces a register side effect
  p_bad_no_side_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.badAccess |-> (strb.w1c == '0 && strb.maskSet == '0 &&
                        strb.maskClr == '0 && !strb.srcClr && !strb.dstClr));
endmodule

// File: rtl/irq_ctl_dp.sv
module irq_ctl_dp
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] hwSet,
  input  ctlStrb_t          strb,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] maskQ,
  output logic [CNT_W-1:0]  srcCnt,
  output logic [CNT_W-1:0]  dstCnt,
  output logic              irq
);
  localparam int NSIDE = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cntQ [NSIDE];
  logic [NSIDE-1:0]  inc, clr, wrap;
  logic [STAT_W-1:0] setVec;

  assign inc = {hwSet[B_DST_DONE], hwSet[B_SRC_DONE]};
  assign clr = {strb.dstClr, strb.srcClr};

  for (genvar s = 0; s < NSIDE; s++) begin : g_acct
    localparam int ERR_BIT = (s == 0) ? B_SRC_ACCT : B_DST_ACCT;
    always_ff @(posedge clk) begin
      if (!rstN) cntQ[s] <= '0;
      else       cntQ[s] <= (clr[s] ? '0 : cntQ[s]) + CNT_W'(inc[s]);
    end
    assign wrap[s] = inc[s] && !clr[s] && (cntQ[s] == CNT_MAX);

    // R8: a wrap leaves the counter at zero with its error bit raised
    p_acct_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
      wrap[s] |=> (cntQ[s] == '0 && statusQ[ERR_BIT]));
    // R9: a read-clear without increment leaves zero
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      (clr[s] && !inc[s]) |=> cntQ[s] == '0);
  end

  assign srcCnt = cntQ[0];
  assign dstCnt = cntQ[1];

  always_comb begin
    setVec = hwSet;
    setVec[B_SRC_ACCT]   = wrap[0];
    setVec[B_DST_ACCT]   = wrap[1];
    setVec[B_BAD_ACCESS] = strb.badAccess;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      statusQ <= (statusQ & ~strb.w1c) | setVec;
      maskQ   <= (maskQ & ~strb.maskClr) | strb.maskSet;
    end
  end

  assign irq = |(statusQ & ~maskQ);

  // R6: an event always lands, even against a same-cycle clear
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet != '0) |=> ((statusQ & $past(hwSet)) == $past(hwSet)));
  // R4: unmasked bits are clear afterwards
  p_mask_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskClr != '0) |=> ((maskQ & $past(strb.maskClr)) == '0));
  // R5: masked bits are set afterwards
  p_mask_dis_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskSet != '0) |=> ((maskQ & $past(strb.maskSet)) == $past(strb.maskSet)));
  // R10: an undecoded access flags bit 0
  p_bad_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.badAccess |=> statusQ[B_BAD_ACCESS]);
  // R4/R5: with no mask write the mask holds
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskSet == '0 && strb.maskClr == '0) |=> $stable(maskQ));
endmodule

// File: rtl/dma_chan_irq_ctl.sv
module dma_chan_irq_ctl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtSrcDone,
  input  logic              evtDstDone,
  input  logic              evtXferDone,
  input  logic              evtPause,
  input  logic              evtWrDataErr,
  input  logic              evtRdDataErr,
  input  logic              evtDstDscrErr,
  input  logic              evtSrcDscrErr,
  input  logic              evtByteOvfl,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [11:0]       regWdata,
  output logic [11:0]       regRdata,
  output logic              irqOut
);
  logic [STAT_W-1:0] hwSet, statusQ, maskQ;
  logic [CNT_W-1:0]  srcCnt, dstCnt;
  ctlStrb_t          strb;

  always_comb begin
    hwSet = '0;
    hwSet[B_SRC_DONE]  = evtSrcDone;
    hwSet[B_DST_DONE]  = evtDstDone;
    hwSet[B_BYTE_OVFL] = evtByteOvfl;
    hwSet[B_SRC_DSCR]  = evtSrcDscrErr;
    hwSet[B_DST_DSCR]  = evtDstDscrErr;
    hwSet[B_RD_DATA]   = evtRdDataErr;
    hwSet[B_WR_DATA]   = evtWrDataErr;
    hwSet[B_XFER_DONE] = evtXferDone;
    hwSet[B_PAUSE]     = evtPause;
  end

  irq_ctl_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .statusQ(statusQ), .maskQ(maskQ), .srcCnt(srcCnt),
    .dstCnt(dstCnt), .strb(strb), .regRdata(regRdata)
  );

  irq_ctl_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .hwSet(hwSet), .strb(strb), .statusQ(statusQ),
    .maskQ(maskQ), .srcCnt(srcCnt), .dstCnt(dstCnt), .irq(irqOut)
  );

  // R3: an interrupt needs an unmasked pending bit
  p_irq_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ((statusQ & ~maskQ) != '0));
endmodule

// File: tb/test_dma_chan_irq_ctl.sv
module test_dma_chan_irq_ctl;
  logic clk = 0;
  logic rstN = 0;
  logic [8:0] evt = '0;
  logic regWr = 0, regRd = 0;
  logic [3:0] regAddr = '0;
  logic [11:0] regWdata = '0;
  logic [11:0] regRdata;
  logic irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [11:0] expStatus, expMask;
  int expSrc, expDst;

  always #2.5 clk = ~clk;

  // evt index: 0 src done,1 dst done,2 xfer done,3 pause,4 wr err,5 rd err,
  // 6 dst dscr err,7 src dscr err,8 byte ovfl
  dma_chan_irq_ctl i_dma_chan_irq_ctl (
    .clk(clk), .rstN(rstN),
    .evtSrcDone(evt[0]), .evtDstDone(evt[1]), .evtXferDone(evt[2]),
    .evtPause(evt[3]), .evtWrDataErr(evt[4]), .evtRdDataErr(evt[5]),
    .evtDstDscrErr(evt[6]), .evtSrcDscrErr(evt[7]), .evtByteOvfl(evt[8]),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic int evtBit(int i);
    case (i)
      0: return 1;  1: return 2;  2: return 10; 3: return 11; 4: return 9;
      5: return 8;  6: return 7;  7: return 6;  default: return 3;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    regWr = 1; regAddr = 4'(a); regWdata = 12'(d);
    cyc(); regWr = 0;
  endtask

  task automatic rd(int a, output int v);
    regRd = 1; regAddr = 4'(a);
    cyc(); regRd = 0; v = int'(regRdata);
  endtask

  // model update for one strobe of event i
  task automatic modelEvt(int i);
    expStatus[evtBit(i)] = 1'b1;
    if (i == 0) begin
      if (expSrc == 255) begin expSrc = 0; expStatus[4] = 1'b1; end
      else expSrc++;
    end
    if (i == 1) begin
      if (expDst == 255) begin expDst = 0; expStatus[5] = 1'b1; end
      else expDst++;
    end
  endtask

  task automatic pulse(int i);
    evt[i] = 1'b1; cyc(); evt[i] = 1'b0;
    modelEvt(i);
  endtask

  task automatic clearAll();
    int v;
    wr(0, 12'hfff); expStatus = '0;
    rd(4, v); rd(5, v); expSrc = 0; expDst = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    expStatus = '0; expMask = '1; expSrc = 0; expDst = 0;
    repeat (3) cyc();
    rstN = 1;
    cyc();

    // R1 reset state
    chk("R1 irq", int'(irqOut), 0);
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 mask", v, 12'hfff);
    rd(4, v); chk("R1 src cnt", v, 0);
    rd(5, v); chk("R1 dst cnt", v, 0);

    // R2 every event sets its own bit, masked so no irq; R7 counts
    for (int i = 0; i < 9; i++) begin
      pulse(i);
      chk("R3 masked irq", int'(irqOut), 0);
      rd(0, v); chk("R2 status bit", v, int'(expStatus));
      if (i < 2) begin
        rd(4 + i, v); chk("R7 counter", v, 1);
        if (i == 0) expSrc = 0; else expDst = 0;
      end
      wr(0, 12'hfff); expStatus = '0;
      rd(0, v); chk("R6 w1c", v, 0);
    end

    // R3 R4 R5 mask sweep over event bits and the bad-access bit
    for (int i = 0; i < 10; i++) begin
      int b, other;
      if (i < 9) begin b = evtBit(i); pulse(i); end
      else begin b = 0; wr(9, 0); expStatus[0] = 1'b1; end
      other = (b + 1) % 12;
      wr(2, 1 << other); expMask[other] = 1'b0;
      chk("R4 other bit irq", int'(irqOut), (expStatus & ~expMask) != 0 ? 1 : 0);
      rd(1, v); chk("R4 mask", v, int'(expMask));
      wr(2, 1 << b); expMask[b] = 1'b0;
      chk("R3 unmasked irq", int'(irqOut), 1);
      wr(3, 12'hfff); expMask = '1;
      chk("R5 remasked irq", int'(irqOut), 0);
      rd(1, v); chk("R5 mask", v, 12'hfff);
      clearAll();
    end

    // R6 event wins against same-cycle clear
    pulse(2);
    regWr = 1; regAddr = 4'd0; regWdata = 12'h400; evt[2] = 1'b1;
    cyc(); regWr = 0; evt[2] = 1'b0;
    rd(0, v); chk("R6 event wins", v, 12'h400);
    wr(0, 12'h400); expStatus = '0;
    rd(0, v); chk("R6 cleared", v, 0);

    // R8 wrap on both sides
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 255; n++) pulse(s);
      rd(0, v); chk("R8 no wrap at 255", (v >> (4 + s)) & 1, 0);
      pulse(s);
      rd(0, v); chk("R8 wrap flag", (v >> (4 + s)) & 1, 1);
      rd(4 + s, v); chk("R8 wrapped count", v, 0);
      clearAll();
    end

    // R9 read-clear with concurrent increment
    for (int s = 0; s < 2; s++) begin
      pulse(s); pulse(s); pulse(s);
      regRd = 1; regAddr = 4'(4 + s); evt[s] = 1'b1;
      cyc(); regRd = 0; evt[s] = 1'b0; v = int'(regRdata);
      chk("R9 read value", v, 3);
      rd(4 + s, v); chk("R9 residual", v, 1);
      rd(0, v); chk("R9 no acct err", (v >> (4 + s)) & 1, 0);
      clearAll();
    end

    // R10 undecoded addresses; R11 zero read data
    for (int a = 6; a < 16; a++) begin
      rd(a, v); chk("R11 undecoded reads zero", v, 0);
      rd(0, v); chk("R10 read flag", v, 1);
      wr(0, 1);
      wr(a, 12'hfff);
      rd(0, v); chk("R10 write flag", v, 1);
      rd(1, v); chk("R10 mask untouched", v, 12'hfff);
      wr(0, 1);
    end
    wr(1, 0);
    rd(1, v); chk("R10 mask write ignored", v, 12'hfff);
    pulse(0);
    wr(4, 12'h0ff);
    rd(4, v); chk("R10 count write ignored", v, 1);
    rd(0, v); chk("R10 no flag on decoded", v & 1, 0);
    clearAll();
    rd(2, v); chk("R11 enable reads zero", v, 0);
    rd(3, v); chk("R11 disable reads zero", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule